// File: doc/BRIEF.md
# Error-Tolerant Serial Sync-Word Detector

This block searches a serial bit stream for a long frame header when the link has no separate clock line. It accepts some bit errors in the header. Each line bit arrives as a data bit together with a one-cycle strobe. The strobes come at a slow line rate, while the logic runs on a much faster system clock. Every strobed bit enters a sliding window that is as long as the header. The window is then scored against a fixed reference word by counting the positions where the two differ.

Scoring uses the idle fast-clock cycles between two line bits. On each strobe, the difference between the window and the reference is frozen into a snapshot. A small engine then walks through the snapshot a few bytes per cycle. A 256-entry ones-count table counts the set bits of each byte, and the engine adds these counts into an accumulator. When the walk is complete, the block reports the mismatch count on a one-cycle valid pulse. If the count does not exceed a threshold set on an input port, it raises a match pulse at the same time.

A receiver uses the match pulse to mark a frame boundary and the reported count as a measure of confidence. The reference word comes from a seed parameter, so the block needs no storage that software loads.

Top module: `sync_word_detector`

## Requirements
- R1: Each strobed bit enters window position 0, and window position k holds the bit strobed k strobes earlier. The bit at position WIN_LEN-1 is dropped on the next strobe. Reset fills the window with zeros.
- R2: The reference bit at position i is bit 0 of a 16-bit register after i update steps. The register starts at SEED, or at 1 if SEED is 0. Each step shifts the register right by one and places (s[0]^s[2]^s[3]^s[5]) into bit 15.
- R3: An accepted strobe produces exactly one `eval_valid` pulse. The pulse appears NSTEP+1 rising edges after the edge that sampled the strobe (17 with the defaults, NSTEP = ceil(ceil(WIN_LEN/8)/LANES)). `eval_errors` then equals the number of positions where the window, as it stood after that strobe, differs from the reference word. The value always lies between 0 and WIN_LEN.
- R4: `eval_match` is 1 with `eval_valid` exactly when `eval_errors <= err_limit`, provided the evaluation is armed (R5). The threshold is inclusive, so a limit of 0 accepts only an exact match.
- R5: An evaluation is armed only if its strobe brought the number of strobes since reset to WIN_LEN or more. The evaluation of the WIN_LEN-th bit is armed. Unarmed evaluations still report their count, but they never raise a match.
- R6: `eval_valid` and `eval_match` each last one cycle. `eval_match` is never 1 without `eval_valid`.
- R7: A strobe is accepted only when no evaluation is in progress. An evaluation is in progress from its strobe edge through its reporting edge, so the minimum strobe spacing is NSTEP+2 cycles. A strobe that arrives during an evaluation still shifts its bit into the window. It starts no evaluation and sets the sticky `overrun` flag.
- R8: Synchronous reset clears `eval_valid`, `eval_match`, `eval_errors` and `overrun`, and restarts the strobe count used by R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| line_bit | input | 1 | Received line bit |
| line_strobe | input | 1 | One-cycle qualifier for `line_bit` |
| err_limit | input | CNT_W | Largest mismatch count accepted as a match |
| eval_valid | output | 1 | One-cycle pulse: `eval_errors` holds a new result |
| eval_match | output | 1 | One-cycle pulse: header found within the limit |
| eval_errors | output | CNT_W | Mismatch count of the latest evaluation |
| overrun | output | 1 | Sticky: a strobe arrived during an evaluation |

## Verification
The bench first shifts in the reference word with the maximum limit. This separates arming on the WIN_LEN-th bit from arming one bit early or late, because every earlier evaluation would otherwise pass the threshold. It then sends the header again with a limit of 0, and with exactly as many flipped bits as the limit and one more. These runs separate an inclusive threshold from an exclusive one and locate off-by-one errors in the count. Pseudo-random bits give counts spread across the whole range, which tests the byte table and the accumulation across lanes. A too-closely spaced strobe followed by a reset shows that a rejected bit still enters the window and that reset clears both the flag and the arming.

// File: rtl/sd_pkg.sv
package sd_pkg;

    localparam int MAX_WIN = 4096;

    typedef logic [255:0][3:0] ones_lut_t;

    typedef enum logic [1:0] {
        ENG_IDLE   = 2'd0,
        ENG_ACCUM  = 2'd1,
        ENG_REPORT = 2'd2
    } eng_state_e;

    function automatic ones_lut_t build_ones_lut();
        ones_lut_t t;
        for (int i = 0; i < 256; i++) begin
            int n;
            n = 0;
            for (int b = 0; b < 8; b++) begin
                n += (i >> b) & 1;
            end
            t[i] = 4'(n);
        end
        return t;
    endfunction

    localparam ones_lut_t ONES_LUT = build_ones_lut();

    function automatic logic [MAX_WIN-1:0] make_pattern(input logic [15:0] seed);
        logic [MAX_WIN-1:0] p;
        logic [15:0]        s;
        logic               fb;
        s = (seed == 16'd0) ? 16'd1 : seed;
        for (int i = 0; i < MAX_WIN; i++) begin
            p[i] = s[0];
            fb   = s[0] ^ s[2] ^ s[3] ^ s[5];
            s    = {fb, s[15:1]};
        end
        return p;
    endfunction

endpackage

// File: rtl/sd_window.sv
module sd_window #(
    parameter int WIN_LEN = 500,
    parameter int CNT_W   = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               line_bit,
    input  logic               line_strobe,
    output logic [WIN_LEN-1:0] win_next,
    output logic               armed_if_strobe
);

    logic [WIN_LEN-1:0] win_q;
    logic [CNT_W-1:0]   fill_cnt;
    logic               full;

    assign win_next        = {win_q[WIN_LEN-2:0], line_bit};
    assign full            = (fill_cnt == CNT_W'(WIN_LEN));
    assign armed_if_strobe = full || (fill_cnt == CNT_W'(WIN_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q    <= '0;
            fill_cnt <= '0;
        end else if (line_strobe) begin
            win_q <= win_next;
            if (!full) begin
                fill_cnt <= fill_cnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/sd_lane_count.sv
module sd_lane_count #(
    parameter int LANES = 4,
    parameter int GS_W  = 6
) (
    input  logic [LANES*8-1:0] bits,
    output logic [GS_W-1:0]    ones
);

    logic [LANES-1:0][3:0] lane_ones;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_ones[l] = sd_pkg::ONES_LUT[bits[l*8 +: 8]];
    end

    always_comb begin
        ones = '0;
        for (int l = 0; l < LANES; l++) begin
            ones = ones + GS_W'(lane_ones[l]);
        end
    end

endmodule

// File: rtl/sd_engine.sv
module sd_engine #(
    parameter int                 WIN_LEN = 500,
    parameter int                 LANES   = 4,
    parameter int                 CNT_W   = 9,
    parameter int                 NSTEP   = 16,
    parameter logic [WIN_LEN-1:0] REF     = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [WIN_LEN-1:0] win_next,
    input  logic               armed_in,
    input  logic [CNT_W-1:0]   err_limit,
    output logic               busy,
    output logic               res_valid,
    output logic               res_match,
    output logic [CNT_W-1:0]   res_count
);

    import sd_pkg::*;

    localparam int GRP_W  = LANES * 8;
    localparam int PAD_W  = NSTEP * GRP_W;
    localparam int GS_W   = $clog2(GRP_W + 1);
    localparam int STEP_W = (NSTEP > 1) ? $clog2(NSTEP) : 1;

    eng_state_e        state;
    logic [PAD_W-1:0]  snap_q;
    logic [STEP_W-1:0] step_q;
    logic [CNT_W-1:0]  acc_q;
    logic [CNT_W-1:0]  acc_next;
    logic              armed_q;
    logic [GS_W-1:0]   grp_ones;

    sd_lane_count #(.LANES(LANES), .GS_W(GS_W)) u_lanes (
        .bits (snap_q[GRP_W-1:0]),
        .ones (grp_ones)
    );

    assign acc_next = acc_q + CNT_W'(grp_ones);
    assign busy     = (state != ENG_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ENG_IDLE;
            snap_q    <= '0;
            step_q    <= '0;
            acc_q     <= '0;
            armed_q   <= 1'b0;
            res_valid <= 1'b0;
            res_match <= 1'b0;
            res_count <= '0;
        end else begin
            res_valid <= 1'b0;
            res_match <= 1'b0;
            case (state)
                ENG_IDLE: begin
                    if (start) begin
                        snap_q  <= PAD_W'(win_next ^ REF);
                        step_q  <= '0;
                        acc_q   <= '0;
                        armed_q <= armed_in;
                        state   <= ENG_ACCUM;
                    end
                end
                ENG_ACCUM: begin
                    acc_q  <= acc_next;
                    snap_q <= snap_q >> GRP_W;
                    step_q <= step_q + STEP_W'(1);
                    if (step_q == STEP_W'(NSTEP - 1)) begin
                        state <= ENG_REPORT;
                    end
                end
                ENG_REPORT: begin
                    res_valid <= 1'b1;
                    res_count <= acc_q;
                    res_match <= armed_q && (acc_q <= err_limit);
                    state     <= ENG_IDLE;
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sync_word_detector.sv
module sync_word_detector #(
    parameter int          WIN_LEN = 500,
    parameter int          LANES   = 4,
    parameter logic [15:0] SEED    = 16'hACE1,
    parameter int          CNT_W   = $clog2(WIN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_bit,
    input  logic             line_strobe,
    input  logic [CNT_W-1:0] err_limit,
    output logic             eval_valid,
    output logic             eval_match,
    output logic [CNT_W-1:0] eval_errors,
    output logic             overrun
);

    localparam int NSLICE = (WIN_LEN + 7) / 8;
    localparam int NSTEP  = (NSLICE + LANES - 1) / LANES;
    localparam logic [sd_pkg::MAX_WIN-1:0] REF_FULL = sd_pkg::make_pattern(SEED);
    localparam logic [WIN_LEN-1:0]         REF_BITS = REF_FULL[WIN_LEN-1:0];

    logic [WIN_LEN-1:0] win_next;
    logic               armed_if_strobe;
    logic               busy;
    logic               overrun_q;

    sd_window #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_window (
        .clk             (clk),
        .rst             (rst),
        .line_bit        (line_bit),
        .line_strobe     (line_strobe),
        .win_next        (win_next),
        .armed_if_strobe (armed_if_strobe)
    );

    sd_engine #(
        .WIN_LEN (WIN_LEN),
        .LANES   (LANES),
        .CNT_W   (CNT_W),
        .NSTEP   (NSTEP),
        .REF     (REF_BITS)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (line_strobe),
        .win_next  (win_next),
        .armed_in  (armed_if_strobe),
        .err_limit (err_limit),
        .busy      (busy),
        .res_valid (eval_valid),
        .res_match (eval_match),
        .res_count (eval_errors)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            overrun_q <= 1'b0;
        end else if (line_strobe && busy) begin
            overrun_q <= 1'b1;
        end
    end

    assign overrun = overrun_q;

endmodule

// File: rtl/sync_word_detector_chk.sv
module sync_word_detector_chk #(
    parameter int WIN_LEN = 500,
    parameter int CNT_W   = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             line_strobe,
    input logic [CNT_W-1:0] err_limit,
    input logic             eval_valid,
    input logic             eval_match,
    input logic [CNT_W-1:0] eval_errors,
    input logic             overrun
);

    logic [CNT_W-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= '0;
        end else if (line_strobe && seen != CNT_W'(WIN_LEN)) begin
            seen <= seen + CNT_W'(1);
        end
    end

    p_errors_bounded_r3: assert property (@(posedge clk) disable iff (rst)
        eval_valid |-> (eval_errors <= CNT_W'(WIN_LEN)));

    p_match_limit_r4: assert property (@(posedge clk) disable iff (rst)
        eval_match |-> (eval_errors <= err_limit));

    p_match_armed_r5: assert property (@(posedge clk) disable iff (rst)
        eval_match |-> (seen == CNT_W'(WIN_LEN)));

    p_match_qualified_r6: assert property (@(posedge clk) disable iff (rst)
        eval_match |-> eval_valid);

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        eval_valid |=> !eval_valid);

    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (!eval_valid && !eval_match && !overrun));

endmodule

bind sync_word_detector sync_word_detector_chk #(
    .WIN_LEN (WIN_LEN),
    .CNT_W   (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .line_strobe (line_strobe),
    .err_limit   (err_limit),
    .eval_valid  (eval_valid),
    .eval_match  (eval_match),
    .eval_errors (eval_errors),
    .overrun     (overrun)
);

// File: tb/sync_word_detector_test.sv
module sync_word_detector_test;

    localparam int WIN     = 500;
    localparam int CNT_W   = 9;
    localparam int LAT     = 17;
    localparam int GAP_MIN = 18;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             line_bit = 1'b0;
    logic             line_strobe = 1'b0;
    logic [CNT_W-1:0] err_limit = '0;
    logic             eval_valid;
    logic             eval_match;
    logic [CNT_W-1:0] eval_errors;
    logic             overrun;

    sync_word_detector uut (
        .clk         (clk),
        .rst         (rst),
        .line_bit    (line_bit),
        .line_strobe (line_strobe),
        .err_limit   (err_limit),
        .eval_valid  (eval_valid),
        .eval_match  (eval_match),
        .eval_errors (eval_errors),
        .overrun     (overrun)
    );

    always #4 clk = ~clk;

    typedef struct {
        int due;
        int cnt;
        bit m;
    } exp_t;

    exp_t           sb[$];
    int             n_checks = 0;
    int             n_fail = 0;
    int             cyc = 0;
    logic [WIN-1:0] ref_w;
    logic [WIN-1:0] mwin = '0;
    int             mfill = 0;
    int             last_edge = -1000;
    int             n_match_seen = 0;
    logic [15:0]    noise = 16'h1D2B;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [WIN-1:0] gen_ref(input logic [15:0] seed);
        logic [WIN-1:0] p;
        logic [15:0]    s;
        s = (seed == 0) ? 16'd1 : seed;
        for (int i = 0; i < WIN; i++) begin
            p[i] = s[0];
            s = {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
        end
        return p;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic send(input logic b, input int gap);
        int   edge_n;
        int   c;
        exp_t e;
        @(negedge clk);
        line_bit    = b;
        line_strobe = 1'b1;
        edge_n      = cyc + 1;
        mwin        = {mwin[WIN-2:0], b};
        if (mfill < WIN) mfill++;
        if (edge_n - last_edge >= GAP_MIN) begin
            last_edge = edge_n;
            c     = $countones(mwin ^ ref_w);
            e.due = edge_n + LAT;
            e.cnt = c;
            e.m   = (mfill >= WIN) && (c <= int'(err_limit));
            sb.push_back(e);
        end
        @(negedge clk);
        line_strobe = 1'b0;
        repeat (gap - 2) @(negedge clk);
    endtask

    task automatic send_header(input int flips);
        for (int i = WIN - 1; i >= 0; i--) begin
            send(ref_w[i] ^ ((i < flips * 50) && (i % 50 == 3)), 20);
        end
    endtask

    task automatic drain();
        repeat (LAT + 6) @(negedge clk);
        chk(sb.size() == 0, "R3 all results delivered", sb.size(), 0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (sb.size() != 0 && cyc > sb[0].due) begin
                chk(1'b0, "R3 result missing", cyc, sb[0].due);
                void'(sb.pop_front());
            end
            if (eval_valid) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R3,R7 unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(cyc == e.due, "R3 latency", cyc, e.due);
                    chk(int'(eval_errors) == e.cnt, "R1,R2,R3 mismatch count", int'(eval_errors), e.cnt);
                    chk(eval_match == e.m, "R4,R5 match decision", int'(eval_match), int'(e.m));
                    if (eval_match) n_match_seen++;
                end
            end else begin
                chk(!eval_match, "R6 match without valid", int'(eval_match), 0);
            end
        end
    end

    bit done = 1'b0;

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        ref_w = gen_ref(16'hACE1);
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(!eval_valid, "R8 valid after reset", int'(eval_valid), 0);
        chk(!eval_match, "R8 match after reset", int'(eval_match), 0);
        chk(!overrun, "R8 overrun after reset", int'(overrun), 0);
        chk(eval_errors == 0, "R8 count after reset", int'(eval_errors), 0);
        rst = 1'b0;

        // R5: widest limit, header shifted in from an empty window
        err_limit = CNT_W'(WIN);
        n_match_seen = 0;
        send_header(0);
        drain();
        chk(n_match_seen == 1, "R5 only the filling bit matches", n_match_seen, 1);

        // R4: exact match required
        err_limit = '0;
        n_match_seen = 0;
        send_header(0);
        drain();
        chk(n_match_seen >= 1, "R4 exact header with limit 0", n_match_seen, 1);

        // R4: flips equal to the limit, then one more
        err_limit = CNT_W'(8);
        n_match_seen = 0;
        send_header(8);
        drain();
        chk(n_match_seen >= 1, "R4 errors at limit accepted", n_match_seen, 1);
        n_match_seen = 0;
        send_header(9);
        drain();
        chk(int'(eval_errors) == 9, "R4 nine errors reported", int'(eval_errors), 9);

        // R1,R2,R3: pseudo-random stream
        for (int i = 0; i < 200; i++) begin
            noise = {noise[0] ^ noise[1] ^ noise[3] ^ noise[12], noise[15:1]};
            send(noise[7], 20);
        end
        drain();

        // R7: strobe too close to the previous one
        chk(!overrun, "R7 no overrun at legal spacing", int'(overrun), 0);
        send(1'b1, 5);
        send(1'b0, 20);
        drain();
        chk(overrun, "R7 overrun flagged", int'(overrun), 1);
        send(1'b1, 20);
        drain();
        chk(overrun, "R7 overrun sticky", int'(overrun), 1);

        // R8: reset mid-stream clears window, flag and arming
        @(negedge clk);
        rst = 1'b1;
        mwin = '0;
        mfill = 0;
        last_edge = -1000;
        repeat (2) @(negedge clk);
        chk(!overrun, "R8 overrun cleared", int'(overrun), 0);
        rst = 1'b0;
        err_limit = CNT_W'(WIN);
        n_match_seen = 0;
        for (int i = 0; i < 12; i++) send(ref_w[WIN - 1 - i], 20);
        drain();
        chk(n_match_seen == 0, "R5 no match before refill", n_match_seen, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule